// File: doc/BRIEF.md
# Link Training Sequencer

This block steps a serial display link through its training procedure. On a start pulse it issues a fixed preparation sequence to the sink and the source: power up, spread setting, lane count, link rate, training start, pattern off. It then runs a clock-recovery phase and, if that phase succeeds, an equalisation phase. A finish phase always follows. Every action leaves the block as one command on a single command channel, given as a kind code and a data byte. The command stays asserted until the transport logic outside the block returns a one-cycle done. The block never talks to the auxiliary channel itself.

While a status-read command completes, the surrounding logic presents the sink's per-lane summaries on the status inputs: clock recovery locked, equalisation done, a read-failure flag, and the swing and pre-emphasis levels the sink asks for on each lane. From these the block computes one drive-setting byte and applies it to all four lanes. It counts retries and decides whether to continue, move to the next phase or give up. All waits are counted in microsecond ticks supplied from outside. At the end the block pulses done, and the pass output shows whether both phases succeeded.

Top module: `dp_link_trainer`

## Requirements
- R1: After start, the first six commands are, in order: kind 1 sink power (data 1), kind 2 spread (data 0x10 when the spread input is set, else 0), kind 3 lane count (lane count in bits 2:0, bit 7 set when enhanced framing is enabled), kind 4 link rate (data = rate input), kind 5 source training start (data 0), kind 6 sink pattern (data 0).
- R2: Clock recovery begins with kind 7 source pattern (data 1), kind 6 sink pattern (data 1) and kind 8 drive update with data 0. The first kind 9 status read is issued no sooner than SETTLE_US plus CR_POLL_US ticks after that drive update.
- R3: Each new drive byte takes the largest swing and the largest pre-emphasis requested over the active lanes only (lanes below the lane count). Swing sits in bits 1:0 and pre-emphasis in bits 4:3. The byte goes to all four 8-bit lane fields of the training-set output and is the data of the following kind 8 command.
- R4: Bit 2 of the drive byte is set exactly when swing is 3, and bit 5 is set exactly when pre-emphasis is 3.
- R5: A clock-recovery status read in which every active lane reports locked ends the phase successfully, and equalisation begins.
- R6: Clock recovery fails when the drive byte applied at the time of a non-locked read already carries the max-swing flag.
- R7: Clock recovery counts consecutive non-locked reads whose applied swing equals the swing at the previous read. It fails when that count reaches 5. A change of swing clears the count.
- R8: Equalisation issues kind 7 and kind 6 with data 3 when the sink supports the third pattern, else data 2. It succeeds when all active lanes report equalised, and it fails on the read at which more than 5 adjustments have already been made.
- R9: A status read that completes with the failure flag ends the current phase as a failure.
- R10: After success or any failure, the block waits at least SETTLE_US ticks, issues kind 6 (data 0) and then kind 10 source complete, and then pulses done for exactly one cycle. Pass is 1 only when both phases succeeded.
- R11: A command, once valid, holds its kind and data unchanged until the cycle of its done.
- R12: After reset no command is valid, done and pass are 0 and the training-set output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken while idle |
| usTick | input | 1 | One-cycle microsecond tick |
| cfgLanes | input | 3 | Active lane count (1, 2 or 4) |
| cfgRate | input | 8 | Link rate code written to the sink |
| cfgSpread | input | 1 | Sink supports downspread |
| cfgEnhanced | input | 1 | Enhanced framing enabled |
| cfgTps3 | input | 1 | Sink supports the third training pattern |
| cmdValid | output | 1 | Command pending |
| cmdKind | output | 4 | Command kind code |
| cmdData | output | 8 | Command data byte |
| cmdDone | input | 1 | Command completed (one cycle) |
| stFail | input | 1 | Status read failed, valid with cmdDone |
| stCrOk | input | 4 | Per-lane clock recovery locked |
| stEqOk | input | 4 | Per-lane equalisation done |
| stAdjSwing | input | 8 | Per-lane requested swing, 2 bits each |
| stAdjEmph | input | 8 | Per-lane requested pre-emphasis, 2 bits each |
| trainSet | output | 32 | Drive byte for each of four lanes |
| trainDone | output | 1 | One-cycle completion pulse |
| trainPass | output | 1 | Training result, valid with trainDone |

## Verification
The bench builds the block with SETTLE_US = 6, CR_POLL_US = 2 and EQ_POLL_US = 3, and keeps the default limits of 5. With these short waits, dozens of complete training runs fit into the run. It sweeps lane counts 1, 2 and 4, three sink request patterns, and early, late and never success points for each phase. This reaches the stall limit, the max-swing abort, the equalisation retry limit, read failures at several points, and the masking of inactive lanes.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [3:0] {
    CMD_NONE      = 4'd0,
    CMD_SINK_PWR  = 4'd1,
    CMD_SPREAD    = 4'd2,
    CMD_LANES     = 4'd3,
    CMD_RATE      = 4'd4,
    CMD_SRC_START = 4'd5,
    CMD_SINK_PAT  = 4'd6,
    CMD_SRC_PAT   = 4'd7,
    CMD_DRIVE     = 4'd8,
    CMD_STATUS    = 4'd9,
    CMD_SRC_DONE  = 4'd10
  } cmdKind_e;

  typedef enum logic [1:0] {
    TMR_SETTLE = 2'd0,
    TMR_CR     = 2'd1,
    TMR_EQ     = 2'd2
  } tmrSel_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_POWER, ST_SPREAD, ST_LANES, ST_RATE, ST_SRC_START, ST_PAT_OFF,
    ST_CR_SRC_PAT, ST_CR_SINK_PAT, ST_CR_DRIVE, ST_CR_SETTLE, ST_CR_WAIT,
    ST_CR_READ, ST_CR_ADJ, ST_EQ_SRC_PAT, ST_EQ_SINK_PAT, ST_EQ_WAIT,
    ST_EQ_READ, ST_EQ_ADJ, ST_FIN_WAIT, ST_FIN_PAT_OFF, ST_FIN_SRC_DONE,
    ST_REPORT
  } ltState_e;

  typedef struct packed {
    logic    loadTimer;
    tmrSel_e timerSel;
    logic    clrTrain;
    logic    adjTrain;
    logic    clrTries;
    logic    crStep;
    logic    eqStep;
  } ltStrobe_t;

  typedef struct packed {
    logic       timerZero;
    logic       allCr;
    logic       allEq;
    logic       allMaxSwing;
    logic       crStallHit;
    logic       eqExhausted;
    logic [7:0] setByte;
  } ltFlags_t;

  localparam int SWING_MAX_BIT = 2;
  localparam int EMPH_MAX_BIT  = 5;
  localparam logic [7:0] SPREAD_ON = 8'h10;
  localparam logic [7:0] ENH_FRAME = 8'h80;

endpackage

// File: rtl/lt_datapath.sv
module lt_datapath
  import lt_pkg::*;
#(
  parameter int NLANES        = 4,
  parameter int SETTLE_US     = 400,
  parameter int CR_POLL_US    = 100,
  parameter int EQ_POLL_US    = 400,
  parameter int CR_SAME_LIMIT = 5,
  parameter int EQ_TRY_LIMIT  = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          usTick,
  input  ltStrobe_t                     strobe,
  input  logic [$clog2(NLANES+1)-1:0]   cfgLanes,
  input  logic [NLANES-1:0]             stCrOk,
  input  logic [NLANES-1:0]             stEqOk,
  input  logic [2*NLANES-1:0]           stAdjSwing,
  input  logic [2*NLANES-1:0]           stAdjEmph,
  output ltFlags_t                      flags,
  output logic [8*NLANES-1:0]           trainSet
);

  localparam int LANE_W  = $clog2(NLANES+1);
  localparam int TMR_MAX = (SETTLE_US > CR_POLL_US) ?
                           ((SETTLE_US > EQ_POLL_US) ? SETTLE_US : EQ_POLL_US) :
                           ((CR_POLL_US > EQ_POLL_US) ? CR_POLL_US : EQ_POLL_US);
  localparam int TMR_W   = $clog2(TMR_MAX+1);
  localparam int TRY_MAX = (CR_SAME_LIMIT > EQ_TRY_LIMIT+1) ? CR_SAME_LIMIT : EQ_TRY_LIMIT+1;
  localparam int TRY_W   = $clog2(TRY_MAX+1);

  logic [NLANES-1:0] laneActive;
  logic [NLANES-1:0] crMiss;
  logic [NLANES-1:0] eqMiss;
  logic [NLANES-1:0] swingRoom;
  logic [1:0]        laneSwing [NLANES];
  logic [1:0]        laneEmph  [NLANES];
  logic [7:0]        laneSet   [NLANES];
  logic [1:0]        maxSwing, maxEmph;
  logic [7:0]        newByte;

  logic [TMR_W-1:0]  timer;
  logic [TRY_W-1:0]  tries;
  logic [1:0]        lastSwing;
  logic              lastValid;
  logic              sameSwing;

  // per-lane masking, status reduction and stored drive byte
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign laneActive[g] = (LANE_W'(g) < cfgLanes);
    assign crMiss[g]     = laneActive[g] & ~stCrOk[g];
    assign eqMiss[g]     = laneActive[g] & ~stEqOk[g];
    assign swingRoom[g]  = laneActive[g] & ~laneSet[g][SWING_MAX_BIT];
    assign laneSwing[g]  = laneActive[g] ? stAdjSwing[2*g +: 2] : 2'd0;
    assign laneEmph[g]   = laneActive[g] ? stAdjEmph[2*g +: 2]  : 2'd0;
    assign trainSet[8*g +: 8] = laneSet[g];

    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrTrain) begin
        laneSet[g] <= 8'd0;
      end else if (strobe.adjTrain) begin
        laneSet[g] <= newByte;
      end
    end
  end

  always_comb begin
    maxSwing = 2'd0;
    maxEmph  = 2'd0;
    for (int l = 0; l < NLANES; l++) begin
      if (laneSwing[l] > maxSwing) maxSwing = laneSwing[l];
      if (laneEmph[l]  > maxEmph)  maxEmph  = laneEmph[l];
    end
    newByte = {2'b00, (maxEmph == 2'd3), maxEmph, (maxSwing == 2'd3), maxSwing};
  end

  // microsecond wait counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.loadTimer) begin
      case (strobe.timerSel)
        TMR_SETTLE: timer <= TMR_W'(SETTLE_US);
        TMR_CR:     timer <= TMR_W'(CR_POLL_US);
        default:    timer <= TMR_W'(EQ_POLL_US);
      endcase
    end else if (usTick && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // retry tracking shared by both phases
  assign sameSwing = lastValid && (laneSet[0][1:0] == lastSwing);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTries) begin
      tries     <= '0;
      lastSwing <= 2'd0;
      lastValid <= 1'b0;
    end else if (strobe.crStep) begin
      tries     <= sameSwing ? tries + 1'b1 : '0;
      lastSwing <= laneSet[0][1:0];
      lastValid <= 1'b1;
    end else if (strobe.eqStep) begin
      tries     <= tries + 1'b1;
    end
  end

  assign flags.timerZero   = (timer == '0);
  assign flags.allCr       = ~|crMiss;
  assign flags.allEq       = ~|eqMiss;
  assign flags.allMaxSwing = ~|swingRoom;
  assign flags.crStallHit  = sameSwing && (tries == TRY_W'(CR_SAME_LIMIT - 1));
  assign flags.eqExhausted = (tries > TRY_W'(EQ_TRY_LIMIT));
  assign flags.setByte     = laneSet[0];

  AST_SWING_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    laneSet[0][SWING_MAX_BIT] == (laneSet[0][1:0] == 2'd3)); // R4
  AST_EMPH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    laneSet[0][EMPH_MAX_BIT] == (laneSet[0][4:3] == 2'd3)); // R4
  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_W'(TRY_MAX)); // R7
  AST_TIMER_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTimer |=> !flags.timerZero); // R2

endmodule

// File: rtl/lt_control.sv
module lt_control
  import lt_pkg::*;
#(
  parameter int NLANES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [$clog2(NLANES+1)-1:0] cfgLanes,
  input  logic [7:0]                  cfgRate,
  input  logic                        cfgSpread,
  input  logic                        cfgEnhanced,
  input  logic                        cfgTps3,
  input  logic                        cmdDone,
  input  logic                        stFail,
  input  ltFlags_t                    flags,
  output ltStrobe_t                   strobe,
  output logic                        cmdValid,
  output cmdKind_e                    cmdKind,
  output logic [7:0]                  cmdData,
  output logic                        trainDone,
  output logic                        trainPass
);

  ltState_e state, nxt;
  logic     passSet;
  logic [7:0] eqPattern;

  assign eqPattern = cfgTps3 ? 8'd3 : 8'd2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trainPass <= 1'b0;
    end else if (state == ST_IDLE && start) begin
      trainPass <= 1'b0;
    end else if (passSet) begin
      trainPass <= 1'b1;
    end
  end

  always_comb begin
    nxt     = state;
    strobe  = '0;
    passSet = 1'b0;
    case (state)
      ST_IDLE:      if (start)   nxt = ST_POWER;
      ST_POWER:     if (cmdDone) nxt = ST_SPREAD;
      ST_SPREAD:    if (cmdDone) nxt = ST_LANES;
      ST_LANES:     if (cmdDone) nxt = ST_RATE;
      ST_RATE:      if (cmdDone) nxt = ST_SRC_START;
      ST_SRC_START: if (cmdDone) nxt = ST_PAT_OFF;
      ST_PAT_OFF:   if (cmdDone) nxt = ST_CR_SRC_PAT;
      ST_CR_SRC_PAT: if (cmdDone) nxt = ST_CR_SINK_PAT;
      ST_CR_SINK_PAT: if (cmdDone) begin
        nxt             = ST_CR_DRIVE;
        strobe.clrTrain = 1'b1;
        strobe.clrTries = 1'b1;
      end
      ST_CR_DRIVE: if (cmdDone) begin
        nxt              = ST_CR_SETTLE;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TMR_SETTLE;
      end
      ST_CR_SETTLE: if (flags.timerZero) begin
        nxt              = ST_CR_WAIT;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TMR_CR;
      end
      ST_CR_WAIT: if (flags.timerZero) nxt = ST_CR_READ;
      ST_CR_READ: if (cmdDone) begin
        if (stFail || (!flags.allCr && (flags.allMaxSwing || flags.crStallHit))) begin
          nxt              = ST_FIN_WAIT;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TMR_SETTLE;
        end else if (flags.allCr) begin
          nxt             = ST_EQ_SRC_PAT;
          strobe.clrTries = 1'b1;
        end else begin
          nxt             = ST_CR_ADJ;
          strobe.adjTrain = 1'b1;
          strobe.crStep   = 1'b1;
        end
      end
      ST_CR_ADJ: if (cmdDone) begin
        nxt              = ST_CR_WAIT;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TMR_CR;
      end
      ST_EQ_SRC_PAT: if (cmdDone) nxt = ST_EQ_SINK_PAT;
      ST_EQ_SINK_PAT: if (cmdDone) begin
        nxt              = ST_EQ_WAIT;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TMR_EQ;
      end
      ST_EQ_WAIT: if (flags.timerZero) nxt = ST_EQ_READ;
      ST_EQ_READ: if (cmdDone) begin
        if (stFail || flags.allEq || flags.eqExhausted) begin
          nxt              = ST_FIN_WAIT;
          strobe.loadTimer = 1'b1;
          strobe.timerSel  = TMR_SETTLE;
          passSet          = !stFail && flags.allEq;
        end else begin
          nxt             = ST_EQ_ADJ;
          strobe.adjTrain = 1'b1;
          strobe.eqStep   = 1'b1;
        end
      end
      ST_EQ_ADJ: if (cmdDone) begin
        nxt              = ST_EQ_WAIT;
        strobe.loadTimer = 1'b1;
        strobe.timerSel  = TMR_EQ;
      end
      ST_FIN_WAIT:     if (flags.timerZero) nxt = ST_FIN_PAT_OFF;
      ST_FIN_PAT_OFF:  if (cmdDone) nxt = ST_FIN_SRC_DONE;
      ST_FIN_SRC_DONE: if (cmdDone) nxt = ST_REPORT;
      ST_REPORT:       nxt = ST_IDLE;
      default:         nxt = ST_IDLE;
    endcase
  end

  // command decode from the current state
  always_comb begin
    cmdKind = CMD_NONE;
    cmdData = 8'd0;
    case (state)
      ST_POWER:     begin cmdKind = CMD_SINK_PWR;  cmdData = 8'd1; end
      ST_SPREAD:    begin cmdKind = CMD_SPREAD;    cmdData = cfgSpread ? SPREAD_ON : 8'd0; end
      ST_LANES:     begin cmdKind = CMD_LANES;
                          cmdData = 8'(cfgLanes) | (cfgEnhanced ? ENH_FRAME : 8'd0); end
      ST_RATE:      begin cmdKind = CMD_RATE;      cmdData = cfgRate; end
      ST_SRC_START: cmdKind = CMD_SRC_START;
      ST_PAT_OFF, ST_FIN_PAT_OFF: cmdKind = CMD_SINK_PAT;
      ST_CR_SRC_PAT:  begin cmdKind = CMD_SRC_PAT;  cmdData = 8'd1; end
      ST_CR_SINK_PAT: begin cmdKind = CMD_SINK_PAT; cmdData = 8'd1; end
      ST_EQ_SRC_PAT:  begin cmdKind = CMD_SRC_PAT;  cmdData = eqPattern; end
      ST_EQ_SINK_PAT: begin cmdKind = CMD_SINK_PAT; cmdData = eqPattern; end
      ST_CR_DRIVE, ST_CR_ADJ, ST_EQ_ADJ: begin cmdKind = CMD_DRIVE; cmdData = flags.setByte; end
      ST_CR_READ, ST_EQ_READ: cmdKind = CMD_STATUS;
      ST_FIN_SRC_DONE: cmdKind = CMD_SRC_DONE;
      default: ;
    endcase
  end

  assign cmdValid  = (cmdKind != CMD_NONE);
  assign trainDone = (state == ST_REPORT);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdKind) && $stable(cmdData))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |=> !trainDone); // R10
  AST_PASS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trainPass) |-> (state == ST_FIN_WAIT)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !cmdValid); // R12

endmodule

// File: rtl/dp_link_trainer.sv
module dp_link_trainer
  import lt_pkg::*;
#(
  parameter int NLANES        = 4,
  parameter int SETTLE_US     = 400,
  parameter int CR_POLL_US    = 100,
  parameter int EQ_POLL_US    = 400,
  parameter int CR_SAME_LIMIT = 5,
  parameter int EQ_TRY_LIMIT  = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic                        usTick,
  input  logic [$clog2(NLANES+1)-1:0] cfgLanes,
  input  logic [7:0]                  cfgRate,
  input  logic                        cfgSpread,
  input  logic                        cfgEnhanced,
  input  logic                        cfgTps3,
  output logic                        cmdValid,
  output logic [3:0]                  cmdKind,
  output logic [7:0]                  cmdData,
  input  logic                        cmdDone,
  input  logic                        stFail,
  input  logic [NLANES-1:0]           stCrOk,
  input  logic [NLANES-1:0]           stEqOk,
  input  logic [2*NLANES-1:0]         stAdjSwing,
  input  logic [2*NLANES-1:0]         stAdjEmph,
  output logic [8*NLANES-1:0]         trainSet,
  output logic                        trainDone,
  output logic                        trainPass
);

  ltStrobe_t strobe;
  ltFlags_t  flags;
  cmdKind_e  kindEnum;

  lt_control #(.NLANES(NLANES)) u_control (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgLanes(cfgLanes), .cfgRate(cfgRate), .cfgSpread(cfgSpread),
    .cfgEnhanced(cfgEnhanced), .cfgTps3(cfgTps3),
    .cmdDone(cmdDone), .stFail(stFail), .flags(flags), .strobe(strobe),
    .cmdValid(cmdValid), .cmdKind(kindEnum), .cmdData(cmdData),
    .trainDone(trainDone), .trainPass(trainPass)
  );

  lt_datapath #(
    .NLANES(NLANES), .SETTLE_US(SETTLE_US), .CR_POLL_US(CR_POLL_US),
    .EQ_POLL_US(EQ_POLL_US), .CR_SAME_LIMIT(CR_SAME_LIMIT), .EQ_TRY_LIMIT(EQ_TRY_LIMIT)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .usTick(usTick), .strobe(strobe), .cfgLanes(cfgLanes),
    .stCrOk(stCrOk), .stEqOk(stEqOk), .stAdjSwing(stAdjSwing), .stAdjEmph(stAdjEmph),
    .flags(flags), .trainSet(trainSet)
  );

  assign cmdKind = kindEnum;

endmodule

// File: tb/test_dp_link_trainer.sv
module test_dp_link_trainer;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;
  localparam int CRPOLL     = 2;
  localparam int EQPOLL     = 3;
  localparam int LAT        = 2;
  localparam int LOGMAX     = 128;

  logic clk = 0, rstN = 0, start = 0, usTick = 0;
  logic [2:0] cfgLanes = 3'd1;
  logic [7:0] cfgRate = 8'd0;
  logic cfgSpread = 0, cfgEnhanced = 0, cfgTps3 = 0;
  logic cmdValid;
  logic [3:0] cmdKind;
  logic [7:0] cmdData;
  logic cmdDone = 0, stFail = 0;
  logic [3:0] stCrOk = 0, stEqOk = 0;
  logic [7:0] stAdjSwing = 0, stAdjEmph = 0;
  logic [31:0] trainSet;
  logic trainDone, trainPass;

  dp_link_trainer #(.NLANES(4), .SETTLE_US(SETTLE), .CR_POLL_US(CRPOLL), .EQ_POLL_US(EQPOLL))
  i_dp_link_trainer (
    .clk(clk), .rstN(rstN), .start(start), .usTick(usTick), .cfgLanes(cfgLanes),
    .cfgRate(cfgRate), .cfgSpread(cfgSpread), .cfgEnhanced(cfgEnhanced), .cfgTps3(cfgTps3),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdData(cmdData), .cmdDone(cmdDone),
    .stFail(stFail), .stCrOk(stCrOk), .stEqOk(stEqOk), .stAdjSwing(stAdjSwing),
    .stAdjEmph(stAdjEmph), .trainSet(trainSet), .trainDone(trainDone), .trainPass(trainPass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testCount = 0, failCount = 0, cycles = 0;
  int sLanes, sMode, sCrAt, sEqAt, sFailAt, sTps3, sSpread, sEnh, sRate;
  int logKind [LOGMAX];
  int logData [LOGMAX];
  int logTick [LOGMAX];
  int expKind [LOGMAX];
  int expData [LOGMAX];
  int logN, expN, readIdx, hsErr, tickCnt, latCnt, curKind, curData;
  int expTs, expPass, expCrPass;
  bit active = 0, tickPhase = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sink request patterns per read index and lane
  function automatic int swingReq(input int n, input int l);
    if (sMode == 0) return (n + l) % 4;
    if (sMode == 2) return (l == sLanes - 1) ? ((n > 3) ? 3 : n) : 0;
    return 0;
  endfunction
  function automatic int emphReq(input int n, input int l);
    if (sMode == 0) return (3 * n + 2 * l) % 4;
    if (sMode == 2) return (l == 0) ? ((n > 3) ? 3 : n) : 0;
    return 0;
  endfunction
  function automatic logic [3:0] crOkF(input int n);
    return (n >= sCrAt) ? 4'hF : 4'b1110;
  endfunction
  function automatic logic [3:0] eqOkF(input int n);
    return (n >= sEqAt) ? 4'hF : 4'b0111;
  endfunction
  function automatic bit allActive(input logic [3:0] m);
    for (int l = 0; l < sLanes; l++) if (!m[l]) return 0;
    return 1;
  endfunction
  function automatic int adjByte(input int n);
    int s = 0, e = 0;
    for (int l = 0; l < sLanes; l++) begin
      if (swingReq(n, l) > s) s = swingReq(n, l);
      if (emphReq(n, l) > e) e = emphReq(n, l);
    end
    return s | ((s == 3) ? 4 : 0) | (e << 3) | ((e == 3) ? 32 : 0);
  endfunction

  task automatic push(input int k, input int d);
    if (expN < LOGMAX) begin expKind[expN] = k; expData[expN] = d; end
    expN++;
  endtask

  // reference sequence from the requirements
  task automatic buildExpected();
    int n = 0, ts = 0, last = -1, tries = 0, pat;
    bit fin = 0;
    expN = 0; expPass = 0; expCrPass = 0;
    push(1, 1); push(2, sSpread ? 16 : 0); push(3, sLanes | (sEnh ? 128 : 0));
    push(4, sRate); push(5, 0); push(6, 0);
    push(7, 1); push(6, 1); push(8, 0);
    while (!fin) begin
      push(9, 0);
      if (n == sFailAt) fin = 1;
      else if (allActive(crOkF(n))) begin expCrPass = 1; fin = 1; end
      else if ((ts & 4) != 0) fin = 1;
      else begin
        if ((ts & 3) == last) begin
          tries++;
          if (tries == 5) fin = 1;
        end else tries = 0;
        if (!fin) begin last = ts & 3; ts = adjByte(n); push(8, ts); end
      end
      n++;
    end
    if (expCrPass == 1) begin
      pat = sTps3 ? 3 : 2;
      push(7, pat); push(6, pat);
      tries = 0; fin = 0;
      while (!fin) begin
        push(9, 0);
        if (n == sFailAt) fin = 1;
        else if (allActive(eqOkF(n))) begin expPass = 1; fin = 1; end
        else if (tries > 5) fin = 1;
        else begin ts = adjByte(n); push(8, ts); tries++; end
        n++;
      end
    end
    push(6, 0); push(10, 0);
    expTs = ts;
  endtask

  // tick source and command responder
  always @(negedge clk) begin
    cycles++;
    tickPhase = ~tickPhase;
    usTick = tickPhase;
    if (usTick) tickCnt++;
    if (cmdDone) begin
      cmdDone = 0;
    end else if (active) begin
      if (!cmdValid || int'(cmdKind) != curKind || int'(cmdData) != curData) hsErr++;
      if (latCnt == 0) begin
        active = 0;
        cmdDone = 1;
        if (curKind == 9) begin
          stFail = (readIdx == sFailAt);
          stCrOk = crOkF(readIdx);
          stEqOk = eqOkF(readIdx);
          for (int l = 0; l < 4; l++) begin
            stAdjSwing[2*l +: 2] = 2'(swingReq(readIdx, l));
            stAdjEmph[2*l +: 2]  = 2'(emphReq(readIdx, l));
          end
          readIdx++;
        end
      end else latCnt--;
    end else if (cmdValid && rstN) begin
      active = 1;
      latCnt = LAT;
      curKind = int'(cmdKind);
      curData = int'(cmdData);
      if (logN < LOGMAX) begin
        logKind[logN] = curKind; logData[logN] = curData; logTick[logN] = tickCnt;
      end
      logN++;
    end
  end

  task automatic runScenario(input int lanes, input int mode, input int crAt, input int eqAt,
                             input int failAt, input int idx);
    int wait_ = 0, firstRead = -1, pat = -1;
    bit seqOk, initOk;
    string tag;
    @(negedge clk);
    sLanes = lanes; sMode = mode; sCrAt = crAt; sEqAt = eqAt; sFailAt = failAt;
    sTps3 = idx % 2; sSpread = (idx / 2) % 2; sEnh = (idx / 3) % 2; sRate = 6 + 4 * (idx % 3);
    cfgLanes = 3'(lanes); cfgTps3 = sTps3[0]; cfgSpread = sSpread[0]; cfgEnhanced = sEnh[0];
    cfgRate = 8'(sRate);
    logN = 0; readIdx = 0; hsErr = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!trainDone && wait_ < 5000) begin @(negedge clk); wait_++; end
    check(trainDone == 1, "R10 done reached", wait_, 0);
    buildExpected();
    check(trainPass == expPass[0], "R10 pass result", trainPass, expPass);
    check(trainSet == {4{8'(expTs)}}, "R3 all lanes carry final byte", trainSet, expTs);
    @(negedge clk);
    check(trainDone == 0, "R10 done is one cycle", trainDone, 0);
    initOk = (logN >= 6);
    for (int i = 0; i < 6 && initOk; i++)
      if (logKind[i] != expKind[i] || logData[i] != expData[i]) initOk = 0;
    check(initOk, "R1 preparation commands", logN, 6);
    seqOk = (logN == expN);
    for (int i = 0; i < logN && i < LOGMAX && seqOk; i++) begin
      if (logKind[i] != expKind[i] || logData[i] != expData[i]) begin
        seqOk = 0;
        $display("  entry %0d kind %0d/%0d data %0h/%0h", i, logKind[i], expKind[i],
                 logData[i], expData[i]);
      end
    end
    if (failAt >= 0) tag = "R9 read failure sequence";
    else if (mode == 1 && crAt > 6) tag = "R7 stall sequence";
    else if (crAt > 6) tag = "R6/R4 max swing sequence";
    else if (eqAt > 6) tag = "R8 retry limit sequence";
    else tag = "R5/R3 success sequence";
    check(seqOk, tag, logN, expN);
    for (int i = 0; i < logN && i < LOGMAX; i++)
      if (logKind[i] == 9 && firstRead < 0) firstRead = i;
    check(firstRead > 0 && logTick[firstRead] - logTick[firstRead-1] >= SETTLE + CRPOLL,
          "R2 first read wait", (firstRead > 0) ? logTick[firstRead] - logTick[firstRead-1] : -1,
          SETTLE + CRPOLL);
    check(logN >= 3 && logN <= LOGMAX && logKind[logN-2] == 6 && logKind[logN-1] == 10 &&
          logTick[logN-2] - logTick[logN-3] >= SETTLE,
          "R10 finish order and wait", (logN >= 2 && logN <= LOGMAX) ? logKind[logN-1] : -1, 10);
    if (expCrPass == 1) begin
      for (int i = 9; i < logN && i < LOGMAX; i++)
        if (logKind[i] == 7 && pat < 0) pat = logData[i];
      check(pat == (sTps3 ? 3 : 2), "R8 equalisation pattern", pat, sTps3 ? 3 : 2);
    end
    check(hsErr == 0, "R11 command held until done", hsErr, 0);
  endtask

  initial begin
    int idx = 0;
    sLanes = 1; sMode = 0; sCrAt = 0; sEqAt = 0; sFailAt = -1;
    tickCnt = 0; logN = 0; readIdx = 0; hsErr = 0;
    repeat (4) @(negedge clk);
    check(cmdValid == 0 && trainDone == 0 && trainPass == 0 && trainSet == 0,
          "R12 reset state", {cmdValid, trainDone, trainPass}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(cmdValid == 0 && trainSet == 0, "R12 idle after reset", cmdValid, 0);
    foreach (sLanesList[i]) ;
    for (int li = 0; li < 3; li++) begin
      for (int m = 0; m < 3; m++) begin
        for (int c = 0; c < 3; c++) begin
          for (int e = 0; e < 3; e++) begin
            runScenario((li == 2) ? 4 : li + 1, m, (c == 0) ? 0 : (c == 1) ? 2 : 20,
                        (e == 0) ? 0 : (e == 1) ? 3 : 30, -1, idx);
            idx++;
          end
        end
      end
    end
    for (int f = 0; f < 4; f++) begin
      runScenario(2, 0, 1, 30, (f == 3) ? 7 : f * 2, idx);
      idx++;
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  int sLanesList [1];

  always @(posedge clk) begin
    if (cycles >= 190000) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule